// File: doc/BRIEF.md
# Three-Channel H-Bridge Motor Output Controller

The block drives three independent motor channels. Each channel owns two direction lines, each with its own output-enable, and one PWM line. A single write strobe carries a channel index and a signed duty request in percent. The block picks one of six drive modes from the sign of the duty and that channel's brake-mask bit. It scales the duty magnitude onto a shared up-counter and presents the pin levels, the tri-state enables and the PWM waveform to the bridge drivers.

The brake mask sets what happens during the PWM off-phase. With brake selected, the off-phase shorts the motor through both high sides. With float selected, the off-phase lets the motor coast. The mask is a separate register with its own strobe. A mask bit is read only when a duty write reaches its channel.

Every new mode and compare value waits in a per-channel pending register. It moves to the active register only at the counter's top value, so a PWM period is never cut short or stretched.

Top module: `motor_out_ctrl`

## Requirements
- R1: The compare value is |duty| × TOP / 100, truncated, computed with a 16-bit intermediate. A result above the counter range is clamped to the largest counter value.
- R2: Zero duty on a braking channel drives dir0, dir1 and pwm high, with both enables set.
- R3: Zero duty on a floating channel drives dir0, dir1 and pwm low, with both enables set.
- R4: Positive duty on a floating channel:
  - dir0 is released (enable 0, level 0);
  - dir1 is driven low;
  - pwm is non-inverting.
- R5: Positive duty on a braking channel:
  - dir0 is driven high;
  - dir1 is released (enable 0, level 0);
  - pwm is inverting.
- R6: Negative duty gives the mirror of R4 and R5, with dir0 and dir1 swapped.
- R7: A duty write whose channel index is NUM_CH (3) or more changes no output of any channel.
- R8: The brake mask resets to all ones, so every channel brakes. Bit n belongs to channel n and is 1 for brake. A mask write alone changes no output. The bit is sampled on the next duty write to that channel.
- R9: The counter runs from 0 to TOP and wraps, giving a PWM period of TOP+1 cycles. A written mode and compare value appear on the pins in the first cycle after the counter leaves TOP, and not before.
- R10: Non-inverting pwm is high while counter < compare. Inverting pwm is high while counter >= compare. Either way, the high time per period is the compare value or TOP+1 minus it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Duty write strobe |
| ch_i | input | CH_W | Channel index of the duty write |
| duty_i | input | 8 | Signed duty in percent |
| mask_wr_i | input | 1 | Brake-mask write strobe |
| mask_i | input | NUM_CH | New brake mask, 1 = brake |
| dir0_o | output | NUM_CH | Direction line 0 level per channel |
| dir0_oe_o | output | NUM_CH | Direction line 0 output-enable |
| dir1_o | output | NUM_CH | Direction line 1 level per channel |
| dir1_oe_o | output | NUM_CH | Direction line 1 output-enable |
| pwm_o | output | NUM_CH | PWM line per channel |

## Verification
Some properties are checked on every cycle:
- pins change only right after the counter top;
- at most one direction line is released at a time;
- a static brake or float pattern comes with the matching static pwm level;
- the counter stays in range and wraps;
- only one channel accepts a write, and only for a valid index.

Other behaviour can only be shown by the bench's scenarios. This covers the exact compare arithmetic and PWM polarity, measured as high time per period across every duty from -100 to 100 in both mask states. It also covers the drive levels of each of the six modes, the phase of an update against the counter, the ignored out-of-range index, and the deferred effect of a mask write.

// File: rtl/motor_out_pkg.sv
package motor_out_pkg;

  typedef enum logic [2:0] {
    DM_BRAKE,
    DM_COAST,
    DM_FWD_COAST,
    DM_FWD_BRAKE,
    DM_REV_COAST,
    DM_REV_BRAKE
  } drive_mode_e;

  function automatic drive_mode_e pick_mode(logic signed [7:0] duty, logic brake);
    if (duty == 8'sd0) return brake ? DM_BRAKE : DM_COAST;
    if (duty[7])       return brake ? DM_REV_BRAKE : DM_REV_COAST;
    return brake ? DM_FWD_BRAKE : DM_FWD_COAST;
  endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 8,
  parameter int TOP   = 255
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_top_o
);
  localparam logic [CNT_W-1:0] TOP_V = CNT_W'(TOP);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (cnt_q == TOP_V) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o    = cnt_q;
  assign at_top_o = (cnt_q == TOP_V);

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TOP_V); // R9
  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_top_o |=> (cnt_q == '0)); // R9
endmodule

// File: rtl/duty_scale.sv
module duty_scale #(
  parameter int CNT_W = 8,
  parameter int TOP   = 255
) (
  input  logic signed [7:0] duty_i,
  output logic [CNT_W-1:0]  cmp_o
);
  localparam int PROD_W = 16;
  localparam logic [PROD_W-1:0] CMP_MAX = PROD_W'((1 << CNT_W) - 1);

  logic [7:0]        mag;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quot;

  always_comb begin
    mag   = duty_i[7] ? 8'(-duty_i) : 8'(duty_i);
    prod  = PROD_W'(mag) * PROD_W'(TOP);
    quot  = prod / PROD_W'(100);
    cmp_o = (quot > CMP_MAX) ? CNT_W'(CMP_MAX) : CNT_W'(quot);
    if (mag <= 8'd100) begin
      AST_CMP_BOUND: assert (32'(cmp_o) <= 32'(TOP)); // R1
    end
  end
endmodule

// File: rtl/motor_chan.sv
module motor_chan
  import motor_out_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             at_top_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             hit_i,
  input  drive_mode_e      mode_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             dir0_o,
  output logic             dir0_oe_o,
  output logic             dir1_o,
  output logic             dir1_oe_o,
  output logic             pwm_o
);
  drive_mode_e      pend_mode_q, act_mode_q;
  logic [CNT_W-1:0] pend_cmp_q,  act_cmp_q;
  logic             pend_v_q;

  // staged request, promoted only at counter top
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_mode_q <= DM_BRAKE;
      pend_cmp_q  <= '0;
      pend_v_q    <= 1'b0;
      act_mode_q  <= DM_BRAKE;
      act_cmp_q   <= '0;
    end else if (at_top_i) begin
      pend_v_q <= 1'b0;
      if (hit_i) begin
        act_mode_q <= mode_i;
        act_cmp_q  <= cmp_i;
      end else if (pend_v_q) begin
        act_mode_q <= pend_mode_q;
        act_cmp_q  <= pend_cmp_q;
      end
    end else if (hit_i) begin
      pend_mode_q <= mode_i;
      pend_cmp_q  <= cmp_i;
      pend_v_q    <= 1'b1;
    end
  end

  logic pwm_noninv, pwm_inv;
  assign pwm_noninv = (cnt_i <  act_cmp_q);
  assign pwm_inv    = (cnt_i >= act_cmp_q);

  always_comb begin
    dir0_o = 1'b0; dir0_oe_o = 1'b1;
    dir1_o = 1'b0; dir1_oe_o = 1'b1;
    pwm_o  = 1'b0;
    unique case (act_mode_q)
      DM_BRAKE: begin
        dir0_o = 1'b1; dir1_o = 1'b1; pwm_o = 1'b1;
      end
      DM_COAST: ;
      DM_FWD_COAST: begin
        dir0_oe_o = 1'b0; pwm_o = pwm_noninv;
      end
      DM_FWD_BRAKE: begin
        dir0_o = 1'b1; dir1_oe_o = 1'b0; pwm_o = pwm_inv;
      end
      DM_REV_COAST: begin
        dir1_oe_o = 1'b0; pwm_o = pwm_noninv;
      end
      DM_REV_BRAKE: begin
        dir1_o = 1'b1; dir0_oe_o = 1'b0; pwm_o = pwm_inv;
      end
      default: ;
    endcase
  end

  AST_PINS_ONLY_AFTER_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(at_top_i) |-> $stable({dir0_o, dir0_oe_o, dir1_o, dir1_oe_o})); // R9
  AST_ONE_LINE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({~dir0_oe_o, ~dir1_oe_o}) <= 1); // R4
  AST_RELEASED_LEVEL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir0_oe_o |-> !dir0_o) and (!dir1_oe_o |-> !dir1_o)); // R6
  AST_BRAKE_PWM_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir0_o && dir1_o && dir0_oe_o && dir1_oe_o) |-> pwm_o); // R2
  AST_COAST_PWM_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir0_o && !dir1_o && dir0_oe_o && dir1_oe_o) |-> !pwm_o); // R3
endmodule

// File: rtl/motor_out_ctrl.sv
module motor_out_ctrl
  import motor_out_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 8,
  parameter int TOP    = 255,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) + ((NUM_CH & (NUM_CH - 1)) == 0 ? 1 : 0) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [CH_W-1:0]     ch_i,
  input  logic signed [7:0]   duty_i,
  input  logic                mask_wr_i,
  input  logic [NUM_CH-1:0]   mask_i,
  output logic [NUM_CH-1:0]   dir0_o,
  output logic [NUM_CH-1:0]   dir0_oe_o,
  output logic [NUM_CH-1:0]   dir1_o,
  output logic [NUM_CH-1:0]   dir1_oe_o,
  output logic [NUM_CH-1:0]   pwm_o
);
  logic [NUM_CH-1:0] mask_q;
  logic [CNT_W-1:0]  cnt;
  logic              at_top;
  logic [CNT_W-1:0]  cmp;
  logic              ch_ok;
  logic              brake_sel;
  drive_mode_e       req_mode;
  logic [NUM_CH-1:0] hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '1;
    else if (mask_wr_i) mask_q <= mask_i;
  end

  pwm_timebase #(.CNT_W(CNT_W), .TOP(TOP)) u_tb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_o    (cnt),
    .at_top_o (at_top)
  );

  duty_scale #(.CNT_W(CNT_W), .TOP(TOP)) u_scale (
    .duty_i (duty_i),
    .cmp_o  (cmp)
  );

  always_comb begin
    ch_ok     = (32'(ch_i) < NUM_CH);
    brake_sel = 1'b1;
    for (int i = 0; i < NUM_CH; i++)
      if (32'(ch_i) == i) brake_sel = mask_q[i];
    req_mode  = pick_mode(duty_i, brake_sel);
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign hit[g] = wr_i && ch_ok && (32'(ch_i) == g);

    motor_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .at_top_i  (at_top),
      .cnt_i     (cnt),
      .hit_i     (hit[g]),
      .mode_i    (req_mode),
      .cmp_i     (cmp),
      .dir0_o    (dir0_o[g]),
      .dir0_oe_o (dir0_oe_o[g]),
      .dir1_o    (dir1_o[g]),
      .dir1_oe_o (dir1_oe_o[g]),
      .pwm_o     (pwm_o[g])
    );
  end

  AST_SINGLE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit)); // R7
  AST_BAD_CH_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && 32'(ch_i) >= NUM_CH) |-> (hit == '0)); // R7
endmodule

// File: tb/sim_motor_out_ctrl.sv
module sim_motor_out_ctrl;
  localparam int NUM_CH = 3;
  localparam int CNT_W  = 8;
  localparam int TOP    = 19;
  localparam int PER    = TOP + 1;
  localparam int CH_W   = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr = 1'b0;
  logic [CH_W-1:0]   ch = '0;
  logic signed [7:0] duty = '0;
  logic              mask_wr = 1'b0;
  logic [NUM_CH-1:0] mask = '0;
  logic [NUM_CH-1:0] d0, e0, d1, e1, pwm;

  int checks = 0;
  int fails  = 0;
  int ncyc   = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  always @(posedge clk) if (rst_n) ncyc <= ncyc + 1;

  motor_out_ctrl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .TOP(TOP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .ch_i(ch), .duty_i(duty),
    .mask_wr_i(mask_wr), .mask_i(mask),
    .dir0_o(d0), .dir0_oe_o(e0), .dir1_o(d1), .dir1_oe_o(e1), .pwm_o(pwm)
  );

  // {dir0, oe0, dir1, oe1}
  function automatic logic [3:0] exp_pins(int d, bit brk);
    if (d == 0) return brk ? 4'b1111 : 4'b0101;
    if (d > 0)  return brk ? 4'b1100 : 4'b0001;
    return brk ? 4'b0011 : 4'b0100;
  endfunction

  function automatic int exp_high(int d, bit brk);
    int mag, c;
    mag = (d < 0) ? -d : d;
    c = (mag * TOP) / 100;
    if (d == 0) return brk ? PER : 0;
    return brk ? PER - c : c;
  endfunction

  function automatic logic [3:0] pins(int c);
    return {d0[c], e0[c], d1[c], e1[c]};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic count_high(int c, output int n);
    n = 0;
    repeat (PER) begin
      @(negedge clk);
      n += int'(pwm[c]);
    end
  endtask

  task automatic write_duty(int c, int d);
    @(negedge clk);
    wr = 1'b1; ch = CH_W'(c); duty = 8'(d);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic write_mask(logic [NUM_CH-1:0] m);
    @(negedge clk);
    mask_wr = 1'b1; mask = m;
    @(negedge clk);
    mask_wr = 1'b0;
  endtask

  task automatic settle();
    repeat (2 * PER + 3) @(negedge clk);
  endtask

  task automatic check_chan(int c, int d, bit brk, string req);
    int n;
    check(pins(c) == exp_pins(d, brk), req, pins(c), exp_pins(d, brk));
    count_high(c, n);
    check(n == exp_high(d, brk), {req, "/R1/R10"}, n, exp_high(d, brk));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] snap_p [NUM_CH];
    int         snap_n [NUM_CH];
    int         n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R8 R2: reset state brakes every channel
    for (int c = 0; c < NUM_CH; c++) check_chan(c, 0, 1'b1, "R8/R2 reset");

    // sweep both mask states, every duty
    for (int b = 0; b < 2; b++) begin
      write_mask(b[0] ? '1 : '0);
      for (int d = -100; d <= 100; d++) begin
        int c;
        string req;
        c = (d + 300) % NUM_CH;
        req = (d == 0) ? (b[0] ? "R2" : "R3") :
              (d > 0)  ? (b[0] ? "R5" : "R4") : "R6";
        write_duty(c, d);
        settle();
        check_chan(c, d, b[0], req);
      end
    end

    // R7: out-of-range channel index ignored
    write_mask('1);
    for (int c = 0; c < NUM_CH; c++) write_duty(c, 30 + 10 * c);
    settle();
    for (int c = 0; c < NUM_CH; c++) begin
      snap_p[c] = pins(c);
      count_high(c, snap_n[c]);
    end
    write_duty(3, -70);
    settle();
    for (int c = 0; c < NUM_CH; c++) begin
      check(pins(c) == snap_p[c], "R7 pins", pins(c), snap_p[c]);
      count_high(c, n);
      check(n == snap_n[c], "R7 pwm", n, snap_n[c]);
    end

    // R8: mask write alone does not change a channel
    write_duty(0, 40);
    settle();
    write_mask('0);
    settle();
    check_chan(0, 40, 1'b1, "R8 deferred");
    write_duty(0, 40);
    settle();
    check_chan(0, 40, 1'b0, "R8 applied");

    // R9: update lands only after the counter top
    write_duty(1, 0);
    settle();
    while ((ncyc % PER) != 5) @(negedge clk);
    wr = 1'b1; ch = 2'd1; duty = 8'sd50;
    @(negedge clk);
    wr = 1'b0;
    while ((ncyc % PER) != TOP) @(negedge clk);
    check(pins(1) == exp_pins(0, 1'b0), "R9 before top", pins(1), exp_pins(0, 1'b0));
    @(negedge clk);
    check(pins(1) == exp_pins(50, 1'b0), "R9 after top", pins(1), exp_pins(50, 1'b0));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule